// File: doc/BRIEF.md
# Shared circular receive buffer manager

This block sits beside the receive path of a serial-bus remote terminal. For every data word the decoder hands over, it decides from the owning subaddress's control word whether that word goes into one common ring. Any subset of the receive and broadcast subaddresses can share this ring. If the word is taken, the block supplies the RAM write address. It also supplies the write-back of the updated ring pointer and raises single-cycle interrupts at the half-way point and at rollover.

The ring lives in a region aligned to its largest size at `BASE_ADDR`. A 3-bit size code selects its length. Two pointers are kept, one per buffer area, and the active-area select picks which one is used and which memory slot holds it. The RAM, command decoding and the per-subaddress private buffers sit outside.

Top module: `sring_mgr`

## Requirements
- R1: A non-broadcast valid word is routed to the ring (`use_ring`=1 in the same cycle) only when `sa_ctrl` bits 15, 7, 6 and 5 are all 1.
- R2: With `sep_bcast_en`=1, a broadcast valid word is routed only when `sa_ctrl` bits 15, 2, 1 and 0 are all 1. Bits 7..5 then have no effect.
- R3: With `sep_bcast_en`=0, a broadcast word uses the same enable bits as R1 (15, 7, 6, 5).
- R4: A routed word's `wr_addr` is `BASE_ADDR` plus the active area's current offset, and that offset advances by one after the word. When nothing is routed, `wr_addr` is 0 and no pointer moves, whether `word_valid` is low or the control bits miss.
- R5: Size code n gives a ring of 128·2^n words. Offsets wrap modulo that size, so the address bits above the ring stay equal to `BASE_ADDR`.
- R6: `ptr_slot_addr` is 0x0101 when area A is active (`area_b`=0) and 0x0105 when area B is active. A routed word pulses `ptr_slot_we` in the same cycle, with `ptr_slot_wdata` carrying the advanced pointer. Otherwise `ptr_slot_wdata` is 0.
- R7: `half_irq` pulses for one cycle, in the cycle after a routed word written at offset size/2−1, only if `half_irq_en` was 1 with that word.
- R8: `wrap_irq` pulses for one cycle, in the cycle after a routed word written at the last offset (size−1), only if `wrap_irq_en` was 1 with that word.
- R9: Areas A and B keep independent pointers. Words routed in one area leave the other area's pointer unchanged.
- R10: After reset both pointers are at offset 0, and both interrupts and `use_ring` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| word_valid | input | 1 | A received data word is presented this cycle |
| is_bcast | input | 1 | The word belongs to a broadcast message |
| sep_bcast_en | input | 1 | Broadcast words use their own enable bits |
| area_b | input | 1 | Active area select: 0 area A, 1 area B |
| size_code | input | 3 | Ring size code n, 128·2^n words |
| sa_ctrl | input | 16 | Control word of the word's subaddress |
| half_irq_en | input | 1 | Enable for the half-way interrupt |
| wrap_irq_en | input | 1 | Enable for the rollover interrupt |
| use_ring | output | 1 | Word is stored in the shared ring |
| wr_addr | output | 16 | RAM write address for the word |
| ptr_slot_addr | output | 16 | Memory slot holding the active pointer |
| ptr_slot_we | output | 1 | Pointer write-back strobe |
| ptr_slot_wdata | output | 16 | Advanced pointer value to write back |
| half_irq | output | 1 | Half-way interrupt pulse |
| wrap_irq | output | 1 | Rollover interrupt pulse |

## Verification
The bench builds the block with its defaults: 16-bit addresses, a 7-bit minimum ring exponent, a 3-bit size code and a base of 0xC000. Every ring size from 128 to 16384 words is therefore legal. Because the smallest ring has only 128 words, full laps with both interrupt points are short. One half-lap of the 16384-word ring is also affordable, which exercises the widest offset and the topmost mask bits. Changing the size code while a pointer sits high in the ring, and alternating areas, brings the masking and the per-area pointer separation into reach.

// File: rtl/sring_pkg.sv
package sring_pkg;

  // Width of the subaddress control word; bit positions below are fixed
  localparam int unsigned CTRL_W = 16;

  // Pointer advance events seen at the current offset
  typedef struct packed {
    logic half_hit;
    logic wrap_hit;
  } ring_evt_t;

  // Low-bit mask for a ring of 2^log2 words
  function automatic logic [31:0] ring_mask32(input int unsigned log2);
    ring_mask32 = (32'd1 << log2) - 32'd1;
  endfunction

  // Enable test: broadcast words with separate data use the low triplet
  function automatic logic ring_enable(input logic [CTRL_W-1:0] ctrl,
                                       input logic bcast,
                                       input logic sep);
    if (bcast && sep)
      ring_enable = ctrl[15] & ctrl[2] & ctrl[1] & ctrl[0];
    else
      ring_enable = ctrl[15] & ctrl[7] & ctrl[6] & ctrl[5];
  endfunction

endpackage

// File: rtl/sring_route.sv
module sring_route
  import sring_pkg::*;
(
  input  logic              word_valid,
  input  logic              is_bcast,
  input  logic              sep_bcast_en,
  input  logic [CTRL_W-1:0] sa_ctrl,
  output logic              route_hit
);

  // Bits no routing choice looks at
  logic unused_ctrl;
  assign unused_ctrl = ^{sa_ctrl[14:8], sa_ctrl[4:3]};

  always_comb begin
    route_hit = word_valid & ring_enable(sa_ctrl, is_bcast, sep_bcast_en);
  end

endmodule

// File: rtl/sring_ptr.sv
module sring_ptr
  import sring_pkg::*;
#(
  parameter int unsigned OW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic [OW-1:0] mask,
  output logic [OW-1:0] cur_off,
  output logic [OW-1:0] nxt_off,
  output ring_evt_t     evt
);

  logic [OW-1:0] off_q;

  always_comb begin
    cur_off      = off_q & mask;
    nxt_off      = (cur_off + OW'(1)) & mask;
    evt.half_hit = (cur_off == (mask >> 1));
    evt.wrap_hit = (cur_off == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   off_q <= '0;
    else if (adv) off_q <= nxt_off;
  end

endmodule

// File: rtl/sring_irq.sv
module sring_irq
  import sring_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      adv,
  input  ring_evt_t evt,
  input  logic      half_en,
  input  logic      wrap_en,
  output logic      half_irq,
  output logic      wrap_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_irq <= 1'b0;
      wrap_irq <= 1'b0;
    end else begin
      half_irq <= adv & half_en & evt.half_hit;
      wrap_irq <= adv & wrap_en & evt.wrap_hit;
    end
  end

endmodule

// File: rtl/sring_mgr.sv
module sring_mgr
  import sring_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned SZW       = 3,
  parameter int unsigned MIN_LOG2  = 7,
  parameter logic [15:0] BASE_ADDR = 16'hC000,
  parameter logic [15:0] SLOT_A    = 16'h0101,
  parameter logic [15:0] SLOT_B    = 16'h0105
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic              is_bcast,
  input  logic              sep_bcast_en,
  input  logic              area_b,
  input  logic [SZW-1:0]    size_code,
  input  logic [CTRL_W-1:0] sa_ctrl,
  input  logic              half_irq_en,
  input  logic              wrap_irq_en,
  output logic              use_ring,
  output logic [AW-1:0]     wr_addr,
  output logic [AW-1:0]     ptr_slot_addr,
  output logic              ptr_slot_we,
  output logic [AW-1:0]     ptr_slot_wdata,
  output logic              half_irq,
  output logic              wrap_irq
);

  localparam int unsigned OW     = MIN_LOG2 + (1 << SZW) - 1;
  localparam int unsigned NAREAS = 2;

  logic [OW-1:0] ring_mask;
  logic [OW-1:0] cur_off [NAREAS];
  logic [OW-1:0] nxt_off [NAREAS];
  ring_evt_t     evt     [NAREAS];
  logic          route_hit;
  logic [OW-1:0] sel_cur;
  logic [OW-1:0] sel_nxt;
  ring_evt_t     sel_evt;

  assign ring_mask = OW'(ring_mask32(MIN_LOG2 + 32'(size_code)));

  sring_route u_route (
    .word_valid   (word_valid),
    .is_bcast     (is_bcast),
    .sep_bcast_en (sep_bcast_en),
    .sa_ctrl      (sa_ctrl),
    .route_hit    (route_hit)
  );

  for (genvar g = 0; g < NAREAS; g++) begin : g_area
    sring_ptr #(.OW(OW)) u_ptr (
      .clk     (clk),
      .rst_n   (rst_n),
      .adv     (route_hit & (area_b == g[0])),
      .mask    (ring_mask),
      .cur_off (cur_off[g]),
      .nxt_off (nxt_off[g]),
      .evt     (evt[g])
    );
  end

  always_comb begin
    sel_cur = area_b ? cur_off[1] : cur_off[0];
    sel_nxt = area_b ? nxt_off[1] : nxt_off[0];
    sel_evt = area_b ? evt[1]     : evt[0];
  end

  sring_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (route_hit),
    .evt      (sel_evt),
    .half_en  (half_irq_en),
    .wrap_en  (wrap_irq_en),
    .half_irq (half_irq),
    .wrap_irq (wrap_irq)
  );

  always_comb begin
    use_ring       = route_hit;
    ptr_slot_we    = route_hit;
    ptr_slot_addr  = area_b ? AW'(SLOT_B) : AW'(SLOT_A);
    wr_addr        = route_hit ? (AW'(BASE_ADDR) | AW'(sel_cur)) : '0;
    ptr_slot_wdata = route_hit ? (AW'(BASE_ADDR) | AW'(sel_nxt)) : '0;
  end

endmodule

// File: rtl/sring_mgr_chk.sv
module sring_mgr_chk
  import sring_pkg::*;
#(
  parameter int unsigned AW        = 16,
  parameter int unsigned SZW       = 3,
  parameter int unsigned MIN_LOG2  = 7,
  parameter logic [15:0] BASE_ADDR = 16'hC000,
  parameter logic [15:0] SLOT_A    = 16'h0101,
  parameter logic [15:0] SLOT_B    = 16'h0105
) (
  input logic           clk,
  input logic           rst_n,
  input logic           word_valid,
  input logic           area_b,
  input logic [SZW-1:0] size_code,
  input logic           half_irq_en,
  input logic           wrap_irq_en,
  input logic           use_ring,
  input logic [AW-1:0]  wr_addr,
  input logic [AW-1:0]  ptr_slot_addr,
  input logic           ptr_slot_we,
  input logic [AW-1:0]  ptr_slot_wdata,
  input logic           half_irq,
  input logic           wrap_irq
);

  logic [AW-1:0] hi_mask;
  assign hi_mask = ~AW'(ring_mask32(MIN_LOG2 + 32'(size_code)));

  // R1 R2 R3: nothing is routed without a valid word
  assert_route_needs_valid_R1: assert property (@(posedge clk) disable iff (!rst_n)
    use_ring |-> word_valid);

  // R5: a routed address never leaves the base-aligned region
  assert_addr_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    use_ring |-> ((wr_addr & hi_mask) == (AW'(BASE_ADDR) & hi_mask)));

  // R5: the written-back pointer stays inside the region too
  assert_wdata_in_region_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_slot_we |-> ((ptr_slot_wdata & hi_mask) == (AW'(BASE_ADDR) & hi_mask)));

  // R6: pointer slot follows the active area
  assert_slot_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_slot_we |-> (ptr_slot_addr == (area_b ? AW'(SLOT_B) : AW'(SLOT_A))));

  // R6: write-back strobe only with a presented word
  assert_slot_we_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_slot_we |-> word_valid);

  // R7: half pulse only after an enabled routed word
  assert_half_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    half_irq |-> ($past(use_ring) && $past(half_irq_en)));

  // R8: rollover pulse only after an enabled routed word
  assert_wrap_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_irq |-> ($past(use_ring) && $past(wrap_irq_en)));

  // R7 R8: the two events fall at different offsets
  assert_irq_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({half_irq, wrap_irq}));

endmodule

bind sring_mgr sring_mgr_chk #(
  .AW(AW), .SZW(SZW), .MIN_LOG2(MIN_LOG2),
  .BASE_ADDR(BASE_ADDR), .SLOT_A(SLOT_A), .SLOT_B(SLOT_B)
) u_chk (
  .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .area_b(area_b),
  .size_code(size_code), .half_irq_en(half_irq_en), .wrap_irq_en(wrap_irq_en),
  .use_ring(use_ring), .wr_addr(wr_addr), .ptr_slot_addr(ptr_slot_addr),
  .ptr_slot_we(ptr_slot_we), .ptr_slot_wdata(ptr_slot_wdata),
  .half_irq(half_irq), .wrap_irq(wrap_irq)
);

// File: tb/sring_mgr_tb.sv
module sring_mgr_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0, is_bcast = 1'b0, sep_bcast_en = 1'b0, area_b = 1'b0;
  logic [2:0]  size_code = 3'd0;
  logic [15:0] sa_ctrl = 16'h0;
  logic        half_irq_en = 1'b0, wrap_irq_en = 1'b0;
  logic        use_ring, ptr_slot_we, half_irq, wrap_irq;
  logic [15:0] wr_addr, ptr_slot_addr, ptr_slot_wdata;

  always #4 clk = ~clk;  // 125 MHz

  sring_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .is_bcast(is_bcast),
    .sep_bcast_en(sep_bcast_en), .area_b(area_b), .size_code(size_code),
    .sa_ctrl(sa_ctrl), .half_irq_en(half_irq_en), .wrap_irq_en(wrap_irq_en),
    .use_ring(use_ring), .wr_addr(wr_addr), .ptr_slot_addr(ptr_slot_addr),
    .ptr_slot_we(ptr_slot_we), .ptr_slot_wdata(ptr_slot_wdata),
    .half_irq(half_irq), .wrap_irq(wrap_irq)
  );

  typedef struct packed {
    logic        use_r;
    logic [15:0] addr;
    logic        we;
    logic [15:0] saddr;
    logic [15:0] wdata;
    logic        half;
    logic        wrap;
    logic [7:0]  tag;
  } exp_t;

  exp_t q[$];
  int   n_chk = 0, n_bad = 0;
  int   offa = 0, offb = 0;
  bit   pend_half = 0, pend_wrap = 0;
  bit   done = 0;
  logic [2:0] cfg_size = 3'd0;
  bit   cfg_hen = 1, cfg_wen = 1;

  // Driver: one call = one cycle; pushes what the outputs must show then
  task automatic drive(input bit v, input bit b, input bit s, input bit ab,
                       input logic [15:0] c, input logic [7:0] tag);
    exp_t e;
    bit   route;
    int   sz, cur, nx;
    @(negedge clk);
    word_valid = v; is_bcast = b; sep_bcast_en = s; area_b = ab; sa_ctrl = c;
    size_code = cfg_size; half_irq_en = cfg_hen; wrap_irq_en = cfg_wen;
    sz = 128 << cfg_size;
    if (b && s) route = v && c[15] && c[2] && c[1] && c[0];
    else        route = v && c[15] && c[7] && c[6] && c[5];
    cur = (ab ? offb : offa) % sz;
    nx  = (cur + 1) % sz;
    e.use_r = route;
    e.addr  = route ? 16'hC000 + 16'(cur) : 16'h0;
    e.we    = route;
    e.saddr = ab ? 16'h0105 : 16'h0101;
    e.wdata = route ? 16'hC000 + 16'(nx) : 16'h0;
    e.half  = pend_half;
    e.wrap  = pend_wrap;
    e.tag   = tag;
    q.push_back(e);
    pend_half = route && cfg_hen && (cur == sz / 2 - 1);
    pend_wrap = route && cfg_wen && (cur == sz - 1);
    if (route) begin
      if (ab) offb = nx;
      else    offa = nx;
    end
  endtask

  task automatic run(input int n, input bit ab, input logic [7:0] tag);
    for (int i = 0; i < n; i++) drive(1, 0, 0, ab, 16'h80E0, tag);
  endtask

  // Monitor: compares every cycle that has an expected item
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (q.size() > 0) begin
        exp_t e;
        exp_t a;
        e = q.pop_front();
        a = '{use_r: use_ring, addr: wr_addr, we: ptr_slot_we, saddr: ptr_slot_addr,
              wdata: ptr_slot_wdata, half: half_irq, wrap: wrap_irq, tag: e.tag};
        n_chk++;
        if (a != e) begin
          n_bad++;
          $display("FAIL R%0d: got use=%b addr=%h we=%b slot=%h wdata=%h half=%b wrap=%b, expected use=%b addr=%h we=%b slot=%h wdata=%h half=%b wrap=%b",
                   e.tag, a.use_r, a.addr, a.we, a.saddr, a.wdata, a.half, a.wrap,
                   e.use_r, e.addr, e.we, e.saddr, e.wdata, e.half, e.wrap);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: idle state after reset
    drive(0, 0, 0, 0, 16'hFFFF, 8'd10);
    drive(0, 0, 0, 1, 16'hFFFF, 8'd10);
    // R1: non-broadcast enable bits 15,7,6,5
    drive(1, 0, 0, 0, 16'h80E0, 8'd1);
    drive(1, 0, 0, 0, 16'h00E0, 8'd1);
    drive(1, 0, 0, 0, 16'h80C0, 8'd1);
    drive(1, 0, 0, 0, 16'h80A0, 8'd1);
    drive(1, 0, 0, 0, 16'h8007, 8'd1);
    drive(1, 0, 1, 0, 16'hFFF8, 8'd1);
    // R2: broadcast with separate data uses bits 15,2,1,0
    drive(1, 1, 1, 0, 16'h8007, 8'd2);
    drive(1, 1, 1, 0, 16'h80E0, 8'd2);
    drive(1, 1, 1, 0, 16'h8006, 8'd2);
    drive(1, 1, 1, 0, 16'h0007, 8'd2);
    // R3: broadcast without separate data uses bits 15,7,6,5
    drive(1, 1, 0, 0, 16'h80E0, 8'd3);
    drive(1, 1, 0, 0, 16'h8007, 8'd3);
    // R4: enable bits present but no valid word: no advance
    drive(0, 0, 0, 0, 16'h80E0, 8'd4);
    drive(1, 0, 0, 0, 16'hFFFF, 8'd4);
    // R9 R6: area B keeps its own pointer and slot
    run(5, 1, 8'd9);
    run(3, 0, 8'd9);
    drive(1, 1, 1, 1, 16'h8007, 8'd6);
    // R7 R8: laps of the 128-word ring in area A
    cfg_size = 3'd0;
    run(300, 0, 8'd8);
    drive(0, 0, 0, 0, 16'h0, 8'd8);
    // R7: half interrupt disabled, rollover still on
    cfg_hen = 0;
    run(200, 0, 8'd7);
    cfg_hen = 1;
    // R8: rollover disabled
    cfg_wen = 0;
    run(130, 1, 8'd8);
    cfg_wen = 1;
    // R5: 256-word ring lap, then shrink while high in the ring
    cfg_size = 3'd1;
    run(400, 0, 8'd5);
    cfg_size = 3'd0;
    run(140, 0, 8'd5);
    // R5: largest ring, half-way and beyond
    cfg_size = 3'd7;
    run(8300, 1, 8'd5);
    cfg_size = 3'd2;
    run(600, 1, 8'd5);
    drive(0, 0, 0, 0, 16'h0, 8'd10);
    drive(0, 0, 0, 1, 16'h0, 8'd10);
    @(negedge clk);
    #6;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule